// File: doc/BRIEF.md
# Strobed Bidirectional Handshake Port

This block is one 8-bit peripheral port that carries data in both directions over a single shared bus. A CPU reaches it through chip select, read and write strobes, a write-data bus, a read-data bus and one select line. With the select line low, the CPU accesses the port data. With it high, the CPU writes commands or reads status. The peripheral sees a tri-stated 8-bit bus and a five-line handshake.

A CPU write loads the output latch and marks the output buffer full. The peripheral pulls acknowledge low to have the latch driven onto the shared bus, and releasing acknowledge frees the buffer. The peripheral pulls strobe low to capture the bus into a separate input latch, which marks the input buffer full. A CPU read of the port data empties that buffer. Two interrupt enables are set and cleared by single-bit commands. A single interrupt request line remembers which event raised it, and that memory decides which CPU access clears it.

All inputs are sampled on `clk`. Each edge is found by comparing a signal with its value one cycle earlier. Every output flag changes on the clock edge where the causing input level is first seen.

Top module: `hs_bidir_port`

## Requirements
- R1: After reset the output-buffer-full flag `obf_n` is high, `ibf` and `intr` are low, and both interrupt enables are clear. The status byte therefore reads 0x80.
- R2: A CPU write with `a_sel`=0 loads `cpu_wdata` into the output latch and drives `obf_n` low on the edge where the write strobe is first seen low.
- R3: The block drives `pa_io` with the output latch only while `ack_n` is low. At all other times it leaves `pa_io` released, so a value the peripheral drives is captured without disturbance.
- R4: A rising edge of `ack_n` returns `obf_n` high.
- R5: While `stb_n` is low, `pa_io` is captured into the input latch and `ibf` goes high. A data read (`a_sel`=0) returns the input latch on `cpu_rdata`, and the end of that read clears `ibf`.
- R6: A command write (`a_sel`=1) with bit 7 clear is a single-bit command: bits 3..1 give the bit number and bit 0 gives the value. Bit number 6 loads enable 1 and bit number 4 loads enable 2. Any other bit number, and any word with bit 7 set, leaves both enables unchanged.
- R7: `intr` is raised by a rising edge of `ack_n` when enable 1 is set, and by a rising edge of `stb_n` when enable 2 is set. With the matching enable clear, these edges do not raise it.
- R8: When only acknowledge raised `intr`, the start of a data write clears it, and a data read leaves it set.
- R9: When only strobe raised `intr`, the start of a data read clears it, and a data write leaves it set.
- R10: When both events raised `intr`, the start of a data write clears it only if the last completed data access was a read. The start of a data read clears it only if the last completed data access was a write.
- R11: A read with `a_sel`=1 returns a status byte with `obf_n` in bit 7, enable 1 in bit 6, `ibf` in bit 5, enable 2 in bit 4, `intr` in bit 3 and zeros in bits 2..0. Status reads and command writes never change `intr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low CPU read strobe |
| wr_n | input | 1 | Active-low CPU write strobe |
| a_sel | input | 1 | 0 selects port data, 1 selects command (write) or status (read) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data; zero when no read is active |
| pa_io | inout | 8 | Shared peripheral bus |
| obf_n | output | 1 | Active-low output buffer full |
| ack_n | input | 1 | Active-low acknowledge from the peripheral |
| stb_n | input | 1 | Active-low strobe from the peripheral |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Interrupt request |

## Verification
Directed sequences raise the interrupt from acknowledge alone, from strobe alone and from both. In each case a data write or data read follows, which separates the three clearing rules from each other. The both-sources case is also run after a read and after a write, which shows that the last completed access decides the clear. The single-bit commands are tried with the selected bit numbers, with unselected bit numbers and with bit 7 set, which separates a real enable change from an ignored word. A seeded random mix of writes, reads, acknowledges, strobes and commands then follows, with the status byte compared to a bench model after every operation.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {LAST_NONE = 2'd0, LAST_RD = 2'd1, LAST_WR = 2'd2} last_e;

  localparam logic [2:0] INTE1_BITNO = 3'd6;
  localparam logic [2:0] INTE2_BITNO = 3'd4;

  // single-bit command targeting a given control bit number
  function automatic logic bsr_hit(input logic [7:0] cmd, input logic [2:0] bitno);
    return (cmd[7] == 1'b0) && (cmd[3:1] == bitno);
  endfunction

  // does this strobe start clear the interrupt, given its sources and history
  function automatic logic intr_clear(input logic src_ack, input logic src_stb,
                                      input logic is_wr, input last_e last);
    if (src_ack && !src_stb) return is_wr;
    if (src_stb && !src_ack) return !is_wr;
    if (src_ack && src_stb)  return is_wr ? (last == LAST_RD) : (last == LAST_WR);
    return 1'b0;
  endfunction

  function automatic logic [7:0] status_byte(input logic obf_n, input logic inte1,
                                             input logic ibf, input logic inte2,
                                             input logic intr);
    return {obf_n, inte1, ibf, inte2, intr, 3'b000};
  endfunction

endpackage

// File: rtl/hs_prev.sv
module hs_prev #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_n,
  output logic [W-1:0] prev_n
);
  // idle level of every active-low strobe is high
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_n[i] <= 1'b1;
      else        prev_n[i] <= lvl_n[i];
    end
  end
endmodule

// File: rtl/hs_port_regs.sv
module hs_port_regs
  import hs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data_ev,
  input  logic          wr_cmd_ev,
  input  logic [DW-1:0] wdata,
  input  logic          ack_rise,
  input  logic          stb_low,
  input  logic [DW-1:0] pa_in,
  input  logic          rd_data_done,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] in_q,
  output logic          obf_n,
  output logic          ibf,
  output logic          inte1,
  output logic          inte2
);
  logic hit1, hit2;
  assign hit1 = wr_cmd_ev && bsr_hit(wdata[7:0], INTE1_BITNO);
  assign hit2 = wr_cmd_ev && bsr_hit(wdata[7:0], INTE2_BITNO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      in_q  <= '0;
      obf_n <= 1'b1;
      ibf   <= 1'b0;
      inte1 <= 1'b0;
      inte2 <= 1'b0;
    end else begin
      if (wr_data_ev) begin
        out_q <= wdata;
        obf_n <= 1'b0;
      end else if (ack_rise) begin
        obf_n <= 1'b1;
      end
      if (stb_low) begin
        in_q <= pa_in;
        ibf  <= 1'b1;
      end else if (rd_data_done) begin
        ibf  <= 1'b0;
      end
      if (hit1) inte1 <= wdata[0];
      if (hit2) inte2 <= wdata[0];
    end
  end

  p_obf_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_ev |=> !obf_n);
  p_obf_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rise && !wr_data_ev) |=> obf_n);
  p_ibf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_low |=> ibf);
  p_bsr_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd_ev && (wdata[7] || (wdata[3:1] != 3'd6 && wdata[3:1] != 3'd4)))
      |=> $stable({inte1, inte2}));
endmodule

// File: rtl/hs_intr.sv
module hs_intr
  import hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_rise,
  input  logic stb_rise,
  input  logic inte1,
  input  logic inte2,
  input  logic wr_start,
  input  logic rd_start,
  input  logic wr_done,
  input  logic rd_done,
  output logic intr
);
  logic  src_ack, src_stb;
  last_e last_q;
  logic  set_ack, set_stb, clr_wr, clr_rd, clr_any;

  assign set_ack = ack_rise && inte1;
  assign set_stb = stb_rise && inte2;
  assign clr_wr  = wr_start && intr_clear(src_ack, src_stb, 1'b1, last_q);
  assign clr_rd  = rd_start && intr_clear(src_ack, src_stb, 1'b0, last_q);
  assign clr_any = clr_wr || clr_rd;
  assign intr    = src_ack || src_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ack <= 1'b0;
      src_stb <= 1'b0;
      last_q  <= LAST_NONE;
    end else begin
      src_ack <= (src_ack && !clr_any) || set_ack;
      src_stb <= (src_stb && !clr_any) || set_stb;
      if (wr_done)      last_q <= LAST_WR;
      else if (rd_done) last_q <= LAST_RD;
    end
  end

  p_rise_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr) |-> $past(set_ack || set_stb));
  p_ack_only_wr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ack && !src_stb && wr_start && !set_ack && !set_stb) |=> !intr);
  p_ack_only_rd_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ack && !src_stb && rd_start) |=> intr);
  p_stb_only_wr_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_stb && !src_ack && wr_start) |=> intr);
  p_both_wr_needs_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ack && src_stb && wr_start && last_q != LAST_RD) |=> intr);
endmodule

// File: rtl/hs_bidir_port.sv
module hs_bidir_port
  import hs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          a_sel,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  inout  wire  [DW-1:0] pa_io,
  output logic          obf_n,
  input  logic          ack_n,
  input  logic          stb_n,
  output logic          ibf,
  output logic          intr
);
  localparam int NSIG = 4;
  localparam int I_WR = 0, I_RD = 1, I_STB = 2, I_ACK = 3;

  logic            rd_act_n, wr_act_n;
  logic [NSIG-1:0] cur_n, prev_n;
  logic            wr_fall, wr_rise, rd_fall, rd_rise, ack_rise, stb_rise;
  logic            wr_sel_q, rd_sel_q;
  logic            wr_start, rd_start, wr_done, rd_done, wr_cmd;
  logic [DW-1:0]   out_q, in_q;
  logic            inte1, inte2;

  assign rd_act_n = cs_n | rd_n;
  assign wr_act_n = cs_n | wr_n;
  assign cur_n    = {ack_n, stb_n, rd_act_n, wr_act_n};

  hs_prev #(.W(NSIG)) u_prev (
    .clk(clk), .rst_n(rst_n), .lvl_n(cur_n), .prev_n(prev_n));

  assign wr_fall  =  prev_n[I_WR]  & ~cur_n[I_WR];
  assign wr_rise  = ~prev_n[I_WR]  &  cur_n[I_WR];
  assign rd_fall  =  prev_n[I_RD]  & ~cur_n[I_RD];
  assign rd_rise  = ~prev_n[I_RD]  &  cur_n[I_RD];
  assign stb_rise = ~prev_n[I_STB] &  cur_n[I_STB];
  assign ack_rise = ~prev_n[I_ACK] &  cur_n[I_ACK];

  // remember which address each strobe started on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
    end else begin
      if (wr_fall) wr_sel_q <= a_sel;
      if (rd_fall) rd_sel_q <= a_sel;
    end
  end

  assign wr_start = wr_fall && !a_sel;
  assign wr_cmd   = wr_fall &&  a_sel;
  assign rd_start = rd_fall && !a_sel;
  assign wr_done  = wr_rise && !wr_sel_q;
  assign rd_done  = rd_rise && !rd_sel_q;

  hs_port_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_data_ev(wr_start), .wr_cmd_ev(wr_cmd), .wdata(cpu_wdata),
    .ack_rise(ack_rise), .stb_low(!stb_n), .pa_in(pa_io),
    .rd_data_done(rd_done),
    .out_q(out_q), .in_q(in_q), .obf_n(obf_n), .ibf(ibf),
    .inte1(inte1), .inte2(inte2));

  hs_intr u_intr (
    .clk(clk), .rst_n(rst_n),
    .ack_rise(ack_rise), .stb_rise(stb_rise),
    .inte1(inte1), .inte2(inte2),
    .wr_start(wr_start), .rd_start(rd_start),
    .wr_done(wr_done), .rd_done(rd_done),
    .intr(intr));

  logic [7:0] status;
  assign status = status_byte(obf_n, inte1, ibf, inte2, intr);

  always_comb begin
    cpu_rdata = '0;
    if (!rd_act_n) begin
      if (a_sel) cpu_rdata[7:0] = status;
      else       cpu_rdata      = in_q;
    end
  end

  assign pa_io = !ack_n ? out_q : {DW{1'bz}};

  p_cmd_keeps_intr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !ack_rise && !stb_rise && (!rd_fall || a_sel)) |=> $stable(intr));
endmodule

// File: tb/hs_bidir_port_tb_top.sv
module hs_bidir_port_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a_sel = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  wire  [7:0] pa_io;
  logic       obf_n, ibf, intr;
  logic       ack_n = 1'b1, stb_n = 1'b1;
  logic       tb_drv = 1'b0;
  logic [7:0] tb_val = '0;

  assign pa_io = tb_drv ? tb_val : 8'bz;
  always #(CLK_P/2) clk = ~clk;

  hs_bidir_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .a_sel(a_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pa_io(pa_io), .obf_n(obf_n), .ack_n(ack_n), .stb_n(stb_n),
    .ibf(ibf), .intr(intr));

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic       m_obf_n = 1, m_ibf = 0, m_e1 = 0, m_e2 = 0, m_sa = 0, m_ss = 0;
  int         m_last = 0; // 0 none, 1 read, 2 write
  logic [7:0] m_out = 0, m_in = 0;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic clears(bit is_wr);
    if (m_sa && m_ss) return is_wr ? (m_last == 1) : (m_last == 2);
    if (m_sa) return is_wr;
    if (m_ss) return !is_wr;
    return 0;
  endfunction

  function automatic logic [7:0] exp_status();
    logic [7:0] s = 8'h00;
    s[7] = m_obf_n; s[6] = m_e1; s[5] = m_ibf; s[4] = m_e2; s[3] = m_sa | m_ss;
    return s;
  endfunction

  task automatic cpu_write(logic sel, logic [7:0] d);
    cs_n = 0; wr_n = 0; a_sel = sel; cpu_wdata = d;
    cyc();
    if (!sel) begin
      if (clears(1)) begin m_sa = 0; m_ss = 0; end
      m_out = d; m_obf_n = 0;
    end else if (!d[7]) begin
      if (d[3:1] == 3'd6) m_e1 = d[0];
      if (d[3:1] == 3'd4) m_e2 = d[0];
    end
    wr_n = 1; cs_n = 1;
    cyc();
    if (!sel) m_last = 2;
  endtask

  task automatic cpu_read(logic sel, output logic [7:0] v);
    cs_n = 0; rd_n = 0; a_sel = sel;
    cyc();
    v = cpu_rdata;
    if (!sel && clears(0)) begin m_sa = 0; m_ss = 0; end
    rd_n = 1; cs_n = 1;
    cyc();
    if (!sel) begin m_ibf = 0; m_last = 1; end
  endtask

  task automatic ack_pulse();
    ack_n = 0;
    cyc();
    check("R3 drive", pa_io, m_out);
    ack_n = 1;
    cyc();
    m_obf_n = 1;
    if (m_e1) m_sa = 1;
  endtask

  task automatic stb_pulse(logic [7:0] v);
    tb_drv = 1; tb_val = v; stb_n = 0;
    cyc();
    m_in = v; m_ibf = 1;
    stb_n = 1;
    cyc();
    tb_drv = 0;
    if (m_e2) m_ss = 1;
  endtask

  task automatic chk_status(string req);
    logic [7:0] v;
    cpu_read(1, v);
    check(req, v, exp_status());
    check(req, {7'b0, intr}, {7'b0, m_sa | m_ss});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 obf_n", {7'b0, obf_n}, 8'h01);
    check("R1 ibf", {7'b0, ibf}, 8'h00);
    check("R1 intr", {7'b0, intr}, 8'h00);
    chk_status("R1 status");
    // R2 write loads latch
    cpu_write(0, 8'hA5);
    check("R2 obf_n low", {7'b0, obf_n}, 8'h00);
    // R3 / R4
    ack_pulse();
    check("R4 obf_n high", {7'b0, obf_n}, 8'h01);
    check("R7 no intr when disabled", {7'b0, intr}, 8'h00);
    // R5 input capture, R3 released bus
    stb_pulse(8'h3C);
    check("R5 ibf set", {7'b0, ibf}, 8'h01);
    cpu_read(0, v);
    check("R5 read data R3 released", v, 8'h3C);
    check("R5 ibf cleared", {7'b0, ibf}, 8'h00);
    // R6 single-bit commands
    cpu_write(1, 8'h0D); chk_status("R6 set e1");
    cpu_write(1, 8'h09); chk_status("R6 set e2");
    cpu_write(1, 8'h04); chk_status("R6 other bit ignored");
    cpu_write(1, 8'h8C); chk_status("R6 bit7 word ignored");
    cpu_write(1, 8'h08); chk_status("R6 clear e2");
    // R7/R8 ack-only interrupt
    cpu_write(0, 8'h11);
    ack_pulse();
    check("R7 ack sets intr", {7'b0, intr}, 8'h01);
    cpu_read(0, v);
    check("R8 read keeps", {7'b0, intr}, 8'h01);
    cpu_write(0, 8'h22);
    check("R8 write clears", {7'b0, intr}, 8'h00);
    // R9 strobe-only
    cpu_write(1, 8'h0C); cpu_write(1, 8'h09);
    stb_pulse(8'h5A);
    check("R7 stb sets intr", {7'b0, intr}, 8'h01);
    cpu_write(0, 8'h33);
    check("R9 write keeps", {7'b0, intr}, 8'h01);
    cpu_read(0, v);
    check("R9 read clears", {7'b0, intr}, 8'h00);
    // R10 both sources, last access was a read
    cpu_write(1, 8'h0D);
    ack_pulse(); stb_pulse(8'h66);
    cpu_read(0, v);
    check("R10 read after read keeps", {7'b0, intr}, 8'h01);
    cpu_write(0, 8'h44);
    check("R10 write after read clears", {7'b0, intr}, 8'h00);
    // R10 both sources, last access was a write
    ack_pulse(); stb_pulse(8'h77);
    cpu_write(0, 8'h55);
    check("R10 write after write keeps", {7'b0, intr}, 8'h01);
    cpu_read(0, v);
    check("R10 read after write clears", {7'b0, intr}, 8'h00);
    chk_status("R11 status");
    // seeded random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      logic [7:0] d;
      op = $urandom % 6;
      d = 8'($urandom);
      case (op)
        0: cpu_write(0, d);
        1: begin cpu_read(0, v); check("R5 random read", v, m_in); end
        2: ack_pulse();
        3: stb_pulse(d);
        4: cpu_write(1, d);
        default: ;
      endcase
      chk_status("R11 random status");
    end
    finish_run();
  end
endmodule